// File: doc/BRIEF.md
# Parallel Host Port Slave Buffer

This block is the slave end of an 8-bit parallel port. An external host uses it to pass bytes to and from the local CPU. A byte written by the host lands in a one-byte receive buffer, together with a tag that says whether it is a command or data. A byte the CPU places in the one-byte transmit buffer is driven back to the host when the host reads. The CPU reaches a control word, a status word and both buffers through a simple register port with a two-bit address. The status word carries these flags:

- receive-full
- transmit-full
- sticky overrun
- command tag
- interrupt

The interrupt flag sets on each completed host write and each completed host read. The CPU clears it by writing 1 to its bit.

Host strobes and the direction pin pass through a two-flop synchronizer. A small state machine then follows each host transaction. The states are:

- `HP_IDLE`: no transaction.
- `HP_WRITE`: a host write strobe is held.
- `HP_READ`: a host read strobe is held; the port drives its data lines.

The transitions are:

- `HP_IDLE -> HP_WRITE`: on a write strobe.
- `HP_IDLE -> HP_READ`: on a read strobe.
- `HP_WRITE -> HP_IDLE`: the strobe falls and the byte is delivered.
- `HP_READ -> HP_IDLE`: the strobe falls and the read is counted as complete.
- `any -> HP_IDLE`: the port is disabled; nothing is delivered.

Work is done only on the trailing edge of a strobe. The host must keep data and the command line stable until four clock cycles after it drops the strobe.

Two pin arrangements are supported:

- Two-strobe arrangement: strobe A writes and strobe B reads.
- Single-strobe arrangement: strobe A serves both directions, and the direction pin chooses (1 = read, 0 = write).

Local register map:

| Address | Register | Access | Fields |
|---|---|---|---|
| 0 | Control | read/write | bit0 port enable, bit1 interrupt enable, bit2 two-strobe arrangement |
| 1 | Status | read; write-1-to-clear on bits 2 and 4 | bit0 receive-full, bit1 transmit-full, bit2 overrun, bit3 command tag, bit4 interrupt flag |
| 2 | Receive buffer | read | byte in bits 7:0 |
| 3 | Transmit buffer | read/write | byte in bits 7:0 |

Upper bits of every register read as zero.

Top module: `hostport_slave`

## Requirements
- R1: After reset, control and status read 0 and `irq` is 0.
- R2: A completed host write stores the byte in the receive buffer and sets receive-full (status bit0). A local read of address 2 returns the byte in bits 7:0 with zero upper bits, and clears receive-full.
- R3: A host write that completes while receive-full is 1 sets overrun (status bit2) and leaves the receive buffer and command tag unchanged. Overrun stays 1 until the CPU writes status with bit2 = 1.
- R4: The interrupt flag (status bit4) sets on every completed host write and every completed host read. A status write with bit4 = 1 clears it, and a status write with bit4 = 0 leaves it unchanged.
- R5: A local write to address 3 loads the transmit byte and sets transmit-full (status bit1). During a host read, `hp_data_oe` is 1 and `hp_data_out` carries the byte. The completed host read clears transmit-full.
- R6: The level of `hp_cmd` during a host write is stored in status bit3 (1 = command, 0 = data).
- R7: With control bit2 = 1, `hp_strb_a` writes and `hp_strb_b` reads. With control bit2 = 0, `hp_strb_a` writes when `hp_dir` = 0 and reads when `hp_dir` = 1, and `hp_strb_b` is ignored.
- R8: `irq` equals the interrupt flag ANDed with control bit1.
- R9: With control bit0 = 0, host strobes change no flag and no buffer.
- R10: While a host write strobe is still held, receive-full stays 0. The byte is taken only on the strobe's trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_data_in | input | 8 | Host data toward the port |
| hp_data_out | output | 8 | Transmit byte toward the host |
| hp_data_oe | output | 1 | Output enable for the host data lines during a read |
| hp_strb_a | input | 1 | Host strobe A, active high (write, or shared strobe) |
| hp_strb_b | input | 1 | Host strobe B, active high (read, two-strobe arrangement only) |
| hp_dir | input | 1 | Direction for the single-strobe arrangement, 1 = read |
| hp_cmd | input | 1 | Host address line: 1 = command, 0 = data |
| lr_wr | input | 1 | Local register write |
| lr_rd | input | 1 | Local register read (side effect: receive-full clear at address 2) |
| lr_addr | input | 2 | Local register address |
| lr_wdata | input | 16 | Local write data |
| lr_rdata | output | 16 | Local read data, valid in the cycle of `lr_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit byte in a 16-bit register word and a two-stage synchronizer. With these values, every host strobe shows its effect a fixed four to five cycles after its trailing edge. The host tasks therefore hold each strobe and each data word for a known number of cycles, and check the status word only after those cycles have passed. Both pin arrangements, the overrun case, the gated interrupt and the disabled port are all driven through the same host and local tasks.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

    typedef enum logic [1:0] {
        HP_IDLE  = 2'd0,
        HP_WRITE = 2'd1,
        HP_READ  = 2'd2
    } hp_state_t;

    localparam int LR_ADDR_W = 2;
    localparam logic [LR_ADDR_W-1:0] REG_CTRL = 2'd0;
    localparam logic [LR_ADDR_W-1:0] REG_STAT = 2'd1;
    localparam logic [LR_ADDR_W-1:0] REG_RXB  = 2'd2;
    localparam logic [LR_ADDR_W-1:0] REG_TXB  = 2'd3;

    localparam int CTRL_W   = 3;
    localparam int CTRL_EN  = 0;
    localparam int CTRL_IE  = 1;
    localparam int CTRL_TWO = 2;

    localparam int STAT_RXF = 0;
    localparam int STAT_TXF = 1;
    localparam int STAT_OVR = 2;
    localparam int STAT_CMD = 3;
    localparam int STAT_IRQ = 4;

endpackage

// File: rtl/hostport_sync.sv
module hostport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] shreg;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shreg <= '0;
                end else begin
                    shreg <= {shreg[STAGES-2:0], d[i]};
                end
            end
            assign q[i] = shreg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/hostport_fsm.sv
module hostport_fsm
    import hostport_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              two_strobe,
    input  logic              s_a,
    input  logic              s_b,
    input  logic              s_dir,
    input  logic [DATA_W-1:0] data_in,
    input  logic              cmd_in,
    output logic              wr_done,
    output logic              rd_done,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_cmd,
    output logic              drive_oe
);

    hp_state_t state, next_state;

    // next state
    always_comb begin
        next_state = state;
        unique case (state)
            HP_IDLE: begin
                if (en) begin
                    if (two_strobe) begin
                        if (s_a)      next_state = HP_WRITE;
                        else if (s_b) next_state = HP_READ;
                    end else if (s_a) begin
                        next_state = s_dir ? HP_READ : HP_WRITE;
                    end
                end
            end
            HP_WRITE: begin
                if (!en || !s_a) next_state = HP_IDLE;
            end
            HP_READ: begin
                if (!en)                             next_state = HP_IDLE;
                else if (two_strobe ? !s_b : !s_a)   next_state = HP_IDLE;
            end
            default: next_state = HP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HP_IDLE;
        else        state <= next_state;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_done <= 1'b0;
            rd_done <= 1'b0;
            wr_byte <= '0;
            wr_cmd  <= 1'b0;
        end else begin
            wr_done <= (state == HP_WRITE) && (next_state == HP_IDLE) && en;
            rd_done <= (state == HP_READ)  && (next_state == HP_IDLE) && en;
            if (state == HP_WRITE) begin
                wr_byte <= data_in;
                wr_cmd  <= cmd_in;
            end
        end
    end

    assign drive_oe = (state == HP_READ);

    // R9: a disabled port drops back to idle
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == HP_IDLE));

    // R7: at most one completion per cycle
    assert_single_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && rd_done));

endmodule

// File: rtl/hostport_regs.sv
module hostport_regs
    import hostport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REG_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lr_wr,
    input  logic                 lr_rd,
    input  logic [LR_ADDR_W-1:0] lr_addr,
    input  logic [REG_W-1:0]     lr_wdata,
    output logic [REG_W-1:0]     lr_rdata,
    input  logic                 wr_done,
    input  logic                 rd_done,
    input  logic [DATA_W-1:0]    wr_byte,
    input  logic                 wr_cmd,
    output logic                 ctrl_en,
    output logic                 ctrl_two,
    output logic [DATA_W-1:0]    tx_byte,
    output logic                 irq
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rx_buf;
    logic              rx_full, rx_cmd, overrun, tx_full, irq_flag;
    logic              wr_ctrl, wr_stat, wr_tx, rx_take;
    logic              unused_wdata;

    assign wr_ctrl = lr_wr && (lr_addr == REG_CTRL);
    assign wr_stat = lr_wr && (lr_addr == REG_STAT);
    assign wr_tx   = lr_wr && (lr_addr == REG_TXB);
    assign rx_take = lr_rd && (lr_addr == REG_RXB);
    assign unused_wdata = ^lr_wdata[REG_W-1:DATA_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            rx_buf   <= '0;
            rx_full  <= 1'b0;
            rx_cmd   <= 1'b0;
            overrun  <= 1'b0;
            tx_byte  <= '0;
            tx_full  <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= lr_wdata[CTRL_W-1:0];

            if (wr_stat && lr_wdata[STAT_OVR]) overrun <= 1'b0;
            if (wr_done) begin
                if (rx_full && !rx_take) begin
                    overrun <= 1'b1;
                end else begin
                    rx_buf  <= wr_byte;
                    rx_cmd  <= wr_cmd;
                    rx_full <= 1'b1;
                end
            end else if (rx_take) begin
                rx_full <= 1'b0;
            end

            if (wr_tx) begin
                tx_byte <= lr_wdata[DATA_W-1:0];
                tx_full <= 1'b1;
            end else if (rd_done) begin
                tx_full <= 1'b0;
            end

            if (wr_done || rd_done)                irq_flag <= 1'b1;
            else if (wr_stat && lr_wdata[STAT_IRQ]) irq_flag <= 1'b0;
        end
    end

    always_comb begin
        lr_rdata = '0;
        unique case (lr_addr)
            REG_CTRL: lr_rdata[CTRL_W-1:0] = ctrl_q;
            REG_STAT: begin
                lr_rdata[STAT_RXF] = rx_full;
                lr_rdata[STAT_TXF] = tx_full;
                lr_rdata[STAT_OVR] = overrun;
                lr_rdata[STAT_CMD] = rx_cmd;
                lr_rdata[STAT_IRQ] = irq_flag;
            end
            REG_RXB: lr_rdata[DATA_W-1:0] = rx_buf;
            REG_TXB: lr_rdata[DATA_W-1:0] = tx_byte;
            default: lr_rdata = '0;
        endcase
    end

    assign ctrl_en  = ctrl_q[CTRL_EN];
    assign ctrl_two = ctrl_q[CTRL_TWO];
    assign irq      = irq_flag && ctrl_q[CTRL_IE];

    // R2: a delivered byte leaves receive-full set
    assert_rxfull_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> rx_full);

    // R3: overrun keeps the old byte and raises the sticky flag
    assert_overrun_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && rx_full && !rx_take) |=> (overrun && rx_buf == $past(rx_buf)));

    // R4: every completion raises the interrupt flag
    assert_irq_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || rd_done) |=> irq_flag);

    // R5: a host read empties the transmit buffer
    assert_txfull_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !wr_tx) |=> !tx_full);

endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
    import hostport_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int REG_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    hp_data_in,
    output logic [DATA_W-1:0]    hp_data_out,
    output logic                 hp_data_oe,
    input  logic                 hp_strb_a,
    input  logic                 hp_strb_b,
    input  logic                 hp_dir,
    input  logic                 hp_cmd,
    input  logic                 lr_wr,
    input  logic                 lr_rd,
    input  logic [LR_ADDR_W-1:0] lr_addr,
    input  logic [REG_W-1:0]     lr_wdata,
    output logic [REG_W-1:0]     lr_rdata,
    output logic                 irq
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] sync_q;
    logic              wr_done, rd_done, wr_cmd, ctrl_en, ctrl_two;
    logic [DATA_W-1:0] wr_byte;

    hostport_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hp_dir, hp_strb_b, hp_strb_a}),
        .q     (sync_q)
    );

    hostport_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl_en),
        .two_strobe (ctrl_two),
        .s_a        (sync_q[0]),
        .s_b        (sync_q[1]),
        .s_dir      (sync_q[2]),
        .data_in    (hp_data_in),
        .cmd_in     (hp_cmd),
        .wr_done    (wr_done),
        .rd_done    (rd_done),
        .wr_byte    (wr_byte),
        .wr_cmd     (wr_cmd),
        .drive_oe   (hp_data_oe)
    );

    hostport_regs #(.DATA_W(DATA_W), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .lr_wr    (lr_wr),
        .lr_rd    (lr_rd),
        .lr_addr  (lr_addr),
        .lr_wdata (lr_wdata),
        .lr_rdata (lr_rdata),
        .wr_done  (wr_done),
        .rd_done  (rd_done),
        .wr_byte  (wr_byte),
        .wr_cmd   (wr_cmd),
        .ctrl_en  (ctrl_en),
        .ctrl_two (ctrl_two),
        .tx_byte  (hp_data_out),
        .irq      (irq)
    );

endmodule

// File: tb/hostport_slave_test.sv
module hostport_slave_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  hp_data_in = '0;
    logic [7:0]  hp_data_out;
    logic        hp_data_oe;
    logic        hp_strb_a = 1'b0, hp_strb_b = 1'b0, hp_dir = 1'b0, hp_cmd = 1'b0;
    logic        lr_wr = 1'b0, lr_rd = 1'b0;
    logic [1:0]  lr_addr = '0;
    logic [15:0] lr_wdata = '0;
    logic [15:0] lr_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    hostport_slave uut (
        .clk(clk), .rst_n(rst_n),
        .hp_data_in(hp_data_in), .hp_data_out(hp_data_out), .hp_data_oe(hp_data_oe),
        .hp_strb_a(hp_strb_a), .hp_strb_b(hp_strb_b), .hp_dir(hp_dir), .hp_cmd(hp_cmd),
        .lr_wr(lr_wr), .lr_rd(lr_rd), .lr_addr(lr_addr), .lr_wdata(lr_wdata),
        .lr_rdata(lr_rdata), .irq(irq)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data as each local read happens
    always @(negedge clk) begin
        #3;
        if (lr_rd) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL scoreboard actual=%h expected=none", lr_rdata);
            end else begin
                chk(lr_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic lwrite(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        lr_wr = 1'b1; lr_addr = a; lr_wdata = d;
        @(negedge clk);
        lr_wr = 1'b0;
    endtask

    task automatic lread(input logic [1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        lr_rd = 1'b1; lr_addr = a;
        @(negedge clk);
        lr_rd = 1'b0;
    endtask

    // host write; single = single-strobe arrangement (dir low)
    task automatic hwrite(input logic [7:0] d, input logic c, input logic single);
        @(negedge clk);
        hp_data_in = d; hp_cmd = c; hp_dir = 1'b0;
        repeat (3) @(negedge clk);
        hp_strb_a = 1'b1;
        repeat (5) @(negedge clk);
        hp_strb_a = 1'b0;
        repeat (8) @(negedge clk);
        if (single) hp_dir = 1'b0;
    endtask

    task automatic hread(input logic [7:0] exp, input logic single, input string tag);
        @(negedge clk);
        if (single) begin
            hp_dir = 1'b1;
            repeat (3) @(negedge clk);
            hp_strb_a = 1'b1;
        end else begin
            hp_strb_b = 1'b1;
        end
        repeat (5) @(negedge clk);
        chk({15'd0, hp_data_oe}, 16'd1, {tag, " oe"});
        chk({8'd0, hp_data_out}, {8'd0, exp}, {tag, " data"});
        hp_strb_a = 1'b0; hp_strb_b = 1'b0;
        repeat (8) @(negedge clk);
        hp_dir = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({15'd0, irq}, 16'd0, "R1 irq");
        lread(2'd0, 16'h0000, "R1 ctrl");
        lread(2'd1, 16'h0000, "R1 status");

        // two-strobe, irq enable, enable
        lwrite(2'd0, 16'h0007);
        lread(2'd0, 16'h0007, "R7 ctrl readback");

        // R2 / R6 / R4: command byte
        hwrite(8'hA5, 1'b1, 1'b0);
        lread(2'd1, 16'h0019, "R2 R6 R4 status after write");
        chk({15'd0, irq}, 16'd1, "R8 irq enabled");
        lread(2'd2, 16'h00A5, "R2 rx byte");
        lread(2'd1, 16'h0018, "R2 rx_full cleared");
        lwrite(2'd1, 16'h0000);
        lread(2'd1, 16'h0018, "R4 write 0 keeps flag");
        lwrite(2'd1, 16'h0010);
        lread(2'd1, 16'h0008, "R4 flag cleared");
        chk({15'd0, irq}, 16'd0, "R8 irq after clear");

        // R3 overrun
        hwrite(8'h3C, 1'b0, 1'b0);
        lread(2'd1, 16'h0011, "R6 data tag");
        hwrite(8'h77, 1'b1, 1'b0);
        lread(2'd1, 16'h0015, "R3 overrun set, tag kept");
        lread(2'd2, 16'h003C, "R3 old byte kept");
        lread(2'd1, 16'h0014, "R3 overrun sticky");
        lwrite(2'd1, 16'h0014);
        lread(2'd1, 16'h0000, "R3 overrun cleared");

        // R5 transmit, two-strobe read
        lwrite(2'd3, 16'h005A);
        lread(2'd1, 16'h0002, "R5 tx_full set");
        hread(8'h5A, 1'b0, "R5 R7 host read");
        lread(2'd1, 16'h0010, "R5 R4 tx_full cleared");
        lwrite(2'd1, 16'h0010);

        // R8 interrupt gated
        lwrite(2'd0, 16'h0005);
        hwrite(8'h11, 1'b0, 1'b0);
        lread(2'd1, 16'h0011, "R8 flag set");
        chk({15'd0, irq}, 16'd0, "R8 irq gated off");
        lread(2'd2, 16'h0011, "R2 second byte");
        lwrite(2'd1, 16'h0010);

        // R7 single-strobe arrangement
        lwrite(2'd0, 16'h0003);
        hwrite(8'hC3, 1'b1, 1'b1);
        lread(2'd1, 16'h0019, "R7 single write");
        lread(2'd2, 16'h00C3, "R7 single byte");
        lwrite(2'd1, 16'h0010);
        @(negedge clk); hp_strb_b = 1'b1;
        repeat (6) @(negedge clk); hp_strb_b = 1'b0;
        repeat (8) @(negedge clk);
        lread(2'd1, 16'h0008, "R7 strobe B ignored");
        lwrite(2'd3, 16'h0096);
        hread(8'h96, 1'b1, "R7 single read");
        lread(2'd1, 16'h0018, "R7 R5 single read done");
        lwrite(2'd1, 16'h0010);

        // R9 disabled
        lwrite(2'd0, 16'h0002);
        hwrite(8'hEE, 1'b0, 1'b0);
        lread(2'd1, 16'h0008, "R9 status unchanged");
        chk({15'd0, irq}, 16'd0, "R9 irq");
        lread(2'd2, 16'h00C3, "R9 rx unchanged");

        // R10 trailing edge
        lwrite(2'd0, 16'h0007);
        @(negedge clk); hp_data_in = 8'h42; hp_cmd = 1'b0;
        repeat (2) @(negedge clk); hp_strb_a = 1'b1;
        repeat (6) @(negedge clk);
        lread(2'd1, 16'h0008, "R10 held strobe");
        @(negedge clk); hp_strb_a = 1'b0;
        repeat (8) @(negedge clk);
        lread(2'd1, 16'h0011, "R10 after trailing edge");
        lread(2'd2, 16'h0042, "R10 byte");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule